// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block turns a 32-bit binary32 bit pattern into a 16-bit binary16 bit pattern. The half-precision result has a sign in bit 15, a 5-bit exponent with bias 15 in bits 14:10, and a 10-bit fraction in bits 9:0. The datapath is a flat set of classifications and a priority select, with no loops and no iterative normalisation. It is followed by one output register.

A caller presents a word together with a valid strobe. Exactly one clock later the converted word appears together with an output valid strobe. The conversion covers normal values, values that fall into the half subnormal range or flush to a signed zero, overflow to infinity, infinities, and NaNs. Rounding is a fixed round-half-away step driven by source fraction bit 12. NaN payloads are kept where they survive truncation. Quiet NaNs collapse to one canonical code.

Top module: `f32_to_f16`

## Requirements
- R1: `res_vld` is high in the cycle after a cycle in which `src_vld` is high, and low otherwise. `res_data` loads only on accepted inputs.
- R2: Output bit 15 equals input bit 31 for every input.
- R3: Normal case: the rebiased exponent is `E - 112`, where E is input bits 30:23. When it lies in 1..30, output bits 14:10 hold that value. Output bits 9:0 hold bits 22:13 of the source fraction after 0x2000 is added to it whenever fraction bit 12 is set.
- R4: When that rounding carries into fraction bit 23, output bits 14:10 hold the rebiased exponent plus one and bits 9:0 are zero. A carry out of exponent 30 gives 0x7C00.
- R5: For a finite input with a rebiased exponent of 31 or more, and for an infinity (E = 255 and fraction zero), output bits 14:0 are 0x7C00.
- R6: A NaN (E = 255, fraction nonzero) whose bit 22 is clear gives bits 14:10 = 0x1F and bits 9:0 = source fraction bits 22:13.
- R7: A NaN of that kind whose fraction bits 22:13 are all zero gives bits 14:0 = 0x7C01.
- R8: Any input with bits 30:22 all ones gives bits 14:0 = 0x7E00.
- R9: When the rebiased exponent is 0 or less, the rounded fraction ORed with 0x800000 is shifted right by (1 - rebiased exponent) and then by 13. Output bits 14:10 are 0 and bits 9:0 hold the shifted value.
- R10: A subnormal shift of 32 or more yields fraction zero. Every input with E below 103 gives bits 14:0 equal to zero (a signed zero).
- R11: After reset, `res_vld` and `res_data` are zero. While `src_vld` is low, `res_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_vld | input | 1 | Input word valid |
| src_data | input | 32 | binary32 bit pattern |
| res_vld | output | 1 | Result valid, one cycle after `src_vld` |
| res_data | output | 16 | binary16 bit pattern |

## Verification
The bench sweeps all 256 source exponents with both signs. Each exponent is paired with a set of fraction patterns: zero, all ones, the lone round bit, just-below and at-tie rounding points, payloads that vanish or survive truncation, the quiet bit, and pseudo-random fills. This sweep separates the normal, carry, overflow, subnormal and flush-to-zero paths at each of their exponent boundaries. At E = 255 it separates infinity, payload NaN, the zero-payload fix and the quiet canonical code. Named points (±0, 2^-24, 2^-25, the largest subnormal, 65504 and 65520) pin the edges. Idle cycles between inputs show that the output valid strobe drops and the held result stays unchanged.

// File: rtl/f32_to_f16.sv
module f32_to_f16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_vld,
  input  logic [31:0] src_data,
  output logic        res_vld,
  output logic [15:0] res_data
);

  logic              sgn;
  logic [7:0]        ex;
  logic [22:0]       fr;
  logic signed [9:0] reb;
  logic [23:0]       frnd;
  logic [9:0]        sub_sa;
  logic [9:0]        sub_frac;
  logic              ex_max, fr_zero, is_inf, is_nan, nan_low0, is_ovf, is_sub, is_qnan, carry;
  logic [14:0]       em;

  assign sgn      = src_data[31];
  assign ex       = src_data[30:23];
  assign fr       = src_data[22:0];
  assign reb      = $signed({2'b00, ex}) - 10'sd112;
  assign frnd     = {1'b0, fr} + {10'd0, fr[12], 13'd0};
  assign carry    = frnd[23];
  assign sub_sa   = 10'(10'sd1 - reb);
  assign sub_frac = (sub_sa >= 10'd32) ? 10'd0
                  : 10'(({1'b1, frnd[22:0]} >> sub_sa[4:0]) >> 13);

  assign ex_max   = &ex;
  assign fr_zero  = (fr == 23'd0);
  assign is_inf   = ex_max & fr_zero;
  assign is_nan   = ex_max & ~fr_zero;
  assign nan_low0 = is_nan & (fr[22:13] == 10'd0);
  assign is_ovf   = ~ex_max & (reb >= 10'sd31);
  assign is_sub   = (reb <= 10'sd0);
  assign is_qnan  = &src_data[30:22];

  always_comb begin
    em = {reb[4:0], frnd[22:13]};
    if (carry)             em = {5'(reb[4:0] + 5'd1), 10'd0};
    if (is_nan)            em = {5'h1F, fr[22:13]};
    if (nan_low0)          em = 15'h7C01;
    if (is_inf || is_ovf)  em = 15'h7C00;
    if (is_sub)            em = {5'd0, sub_frac};
    if (is_qnan)           em = 15'h7E00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_data <= 16'd0;
    end else begin
      res_vld <= src_vld;
      if (src_vld) res_data <= {sgn, em};
    end
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) src_vld |=> res_vld);  // R1
  AST_VLD_DROP:    assert property (@(posedge clk) disable iff (!rst_n) !src_vld |=> !res_vld);  // R1
  AST_SIGN_PASS:   assert property (@(posedge clk) disable iff (!rst_n) src_vld |=> res_data[15] == $past(src_data[31]));  // R2
  AST_QNAN_CANON:  assert property (@(posedge clk) disable iff (!rst_n) (src_vld && (&src_data[30:22])) |=> res_data[14:0] == 15'h7E00);  // R8
  AST_INF_KEEP:    assert property (@(posedge clk) disable iff (!rst_n) (src_vld && src_data[30:0] == 31'h7F800000) |=> res_data[14:0] == 15'h7C00);  // R5
  AST_FLUSH_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) (src_vld && src_data[30:23] < 8'd103) |=> res_data[14:0] == 15'd0);  // R10
  AST_HOLD_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) !src_vld |=> $stable(res_data));  // R11

endmodule

// File: tb/sim_f32_to_f16.sv
module sim_f32_to_f16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_vld = 1'b0;
  logic [31:0] src_data = 32'd0;
  logic        res_vld;
  logic [15:0] res_data;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  f32_to_f16 u0 (.clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_data(src_data),
                 .res_vld(res_vld), .res_data(res_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_conv(input logic [31:0] x, output string tag);
    int e = int'(x[30:23]);
    longint m = longint'(x[22:0]);
    longint mq;
    int eb = e - 112;
    int sa;
    logic [14:0] r;
    mq = m + (((m >> 12) & 1) * 8192);
    if (x[30:22] == 9'h1FF) begin r = 15'h7E00; tag = "R8"; end
    else if (e == 255 && m != 0) begin
      if ((m >> 13) == 0) begin r = 15'h7C01; tag = "R7"; end
      else begin r = 15'(31 * 1024 + (m >> 13)); tag = "R6"; end
    end
    else if (e == 255 || eb >= 31) begin r = 15'h7C00; tag = "R5"; end
    else if (eb <= 0) begin
      sa = 1 - eb;
      if (sa >= 32) begin r = 15'd0; tag = "R10"; end
      else begin r = 15'(((mq | 64'h800000) >> sa) >> 13); tag = (e < 103) ? "R10" : "R9"; end
    end
    else if (mq >= 64'h800000) begin r = 15'((eb + 1) * 1024); tag = "R4"; end
    else begin r = 15'(eb * 1024 + (mq >> 13)); tag = "R3"; end
    return {x[31], r};
  endfunction

  task automatic convert(input logic [31:0] x);
    string tag;
    logic [15:0] exp;
    exp = ref_conv(x, tag);
    @(negedge clk);
    src_vld = 1'b1; src_data = x;
    @(negedge clk);
    src_vld = 1'b0;
    chk("R1 valid", {31'd0, res_vld}, 32'd1);
    chk("R2 sign", {31'd0, res_data[15]}, {31'd0, x[31]});
    chk(tag, {16'd0, res_data}, {16'd0, exp});
  endtask

  initial begin
    logic [31:0] lf = 32'h1D872B41;
    logic [15:0] held;
    logic [22:0] fpat [12];
    fpat = '{23'h0, 23'h7FFFFF, 23'h001000, 23'h002000, 23'h000FFF, 23'h7FE000,
             23'h7FF000, 23'h3FF000, 23'h400000, 23'h000001, 23'h001FFF, 23'h3FFFFF};
    repeat (2) @(negedge clk);
    chk("R11 reset vld", {31'd0, res_vld}, 32'd0);
    chk("R11 reset data", {16'd0, res_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    convert(32'h00000000);
    convert(32'h80000000);
    convert(32'h33800000);
    convert(32'h33000000);
    convert(32'h387FC000);
    convert(32'h477FE000);
    convert(32'h477FF000);
    convert(32'h7F800000);
    convert(32'hFF800000);
    convert(32'h7F800001);
    convert(32'h7FA00000);
    convert(32'hFFC00001);
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 256; e++)
        for (int k = 0; k < 16; k++) begin
          logic [22:0] f;
          if (k < 12) f = fpat[k];
          else begin lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; f = lf[22:0]; end
          convert({s[0], e[7:0], f});
        end
    held = res_data;
    @(negedge clk);
    src_data = 32'h3F800000;
    repeat (3) @(negedge clk);
    chk("R1 idle vld", {31'd0, res_vld}, 32'd0);
    chk("R11 hold", {16'd0, res_data}, {16'd0, held});
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); fails++; checks++; $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule